// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block runs the fixed series of steps that take a small 16-bit CPU from accepting an interrupt to fetching the first instruction of its handler. The sequence starts when a request is pending and the core reaches an instruction boundary. It can also start in the middle of a long string instruction, which is then suspended. Once started, the block owns a simple zero-wait 16-bit bus. On it, the block reads the interrupt information word, lets the instruction queue prefetch if the queue has room, pushes the saved flags and the return address, and fetches the two-word handler vector. The whole sequence takes 18 clock cycles.

The flag register, stack pointer and program counter live in the core. The block samples their values in the cycle it accepts a request. It returns updated values, each with a one-cycle write strobe: the cleared flags, the new priority level, the lowered stack pointer and the handler address. The acknowledge pulse carries the interrupt number so that the matching request bit can be cleared. While the sequence runs, a busy output stalls the fetch unit.

Top module: `irq_entry_seq`

## Requirements
- R1: A request is accepted only in a cycle where `req_i` is high and either `insn_done_i` or `str_susp_i` is high. In that case `busy_o` goes high in the following cycle. Otherwise no sequence starts.
- R2: In step 0 (the first busy cycle) the block reads address 0 and pulses `ack_o`. `ack_num_o` carries the interrupt number. In the information word, the number is in bits [5:0] and the request level is in bits [10:8].
- R3: In steps 1 to 3 the block issues a read at the PC value saved at acceptance, but only in the steps where `q_ready_i` is high.
- R4: In step 4, `flg_we_o` pulses and `flg_o` equals the flags saved at acceptance with three bits cleared: bit 6 (interrupt enable), bit 1 (single-step) and bit 7 (stack select). The 12-bit flag word holds the priority level in bits [10:8].
- R5: Bit 7 keeps its saved value when `sw_int_i` was high at acceptance and the interrupt number is between 32 and 63.
- R6: In step 8 the block writes {pc[19:16], saved flags[11:0]} at SP-2. In step 10 it writes pc[15:0] at SP-4.
- R7: In step 12, `flg_we_o` pulses with the step-4 flags and with bits [10:8] replaced by the request level. In the same cycle `sp_we_o` pulses with `sp_o` equal to SP-4.
- R8: In step 13 the block reads the vector base plus 4 times the number. In step 15 it reads that address plus 2. In step 17, `pc_we_o` pulses with `pc_o` = {second word[3:0], first word}.
- R9: `busy_o` stays high for exactly 18 cycles. A request that is held during the sequence is accepted no earlier than the cycle after `busy_o` falls. Outside the steps listed above, no bus strobe and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | An interrupt request is pending |
| insn_done_i | input | 1 | The current instruction completes this cycle |
| str_susp_i | input | 1 | A suspendable string instruction is running |
| sw_int_i | input | 1 | The entry comes from a software interrupt instruction |
| q_ready_i | input | 1 | The instruction queue can accept a word |
| flg_i | input | 12 | Current flag register |
| pc_i | input | 20 | Current program counter |
| sp_i | input | 16 | Current stack pointer |
| addr_o | output | 20 | Bus address |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe |
| wdata_o | output | 16 | Write data |
| rdata_i | input | 16 | Read data, valid in the same cycle |
| ack_o | output | 1 | Acknowledge pulse that clears the request bit |
| ack_num_o | output | 6 | Number of the acknowledged interrupt |
| busy_o | output | 1 | The sequence is running |
| flg_we_o | output | 1 | Flag register write strobe |
| flg_o | output | 12 | New flag value |
| sp_we_o | output | 1 | Stack pointer write strobe |
| sp_o | output | 16 | New stack pointer |
| pc_we_o | output | 1 | Program counter write strobe |
| pc_o | output | 20 | Handler start address |

## Verification
Every result has a fixed step number, counted from the first busy cycle, which is one cycle after the accepting edge. The ack and the info read come in step 0, the prefetch reads in steps 1 to 3, the flag clear in step 4, and the pushes in steps 8 and 10. The level and SP update come in step 12, the vector reads in steps 13 and 15, and the PC load in step 17. The driver queues each expected event together with its step number. The monitor counts busy cycles at the falling edge, pops each observed strobe and compares its step as well as its address and data. A step that drifts therefore counts as a miscompare even when the values are right.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int AW       = 20;
  localparam int DW       = 16;
  localparam int FW       = 12;
  localparam int NW       = 6;
  localparam int LW       = 3;
  localparam int STEPS    = 18;
  localparam int STW      = $clog2(STEPS);
  // flag bit positions
  localparam int FB_D     = 1;
  localparam int FB_I     = 6;
  localparam int FB_U     = 7;
  localparam int FB_LVL   = 8;
  // information word layout
  localparam int INF_LVL  = 8;
  // step schedule
  localparam logic [STW-1:0] ST_INFO  = STW'(0);
  localparam logic [STW-1:0] ST_QFST  = STW'(1);
  localparam logic [STW-1:0] ST_QLST  = STW'(3);
  localparam logic [STW-1:0] ST_FCLR  = STW'(4);
  localparam logic [STW-1:0] ST_PUSH1 = STW'(8);
  localparam logic [STW-1:0] ST_PUSH2 = STW'(10);
  localparam logic [STW-1:0] ST_LVL   = STW'(12);
  localparam logic [STW-1:0] ST_VLO   = STW'(13);
  localparam logic [STW-1:0] ST_VHI   = STW'(15);
  localparam logic [STW-1:0] ST_LAST  = STW'(STEPS - 1);
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_entry_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_i,
  input  logic           insn_done_i,
  input  logic           str_susp_i,
  output logic           accept_o,
  output logic           run_o,
  output logic [STW-1:0] step_o
);
  logic           run_q, run_d;
  logic [STW-1:0] step_q, step_d;

  assign accept_o = !run_q && req_i && (insn_done_i || str_susp_i);

  always_comb begin
    run_d  = run_q;
    step_d = step_q;
    if (accept_o) begin
      run_d  = 1'b1;
      step_d = '0;
    end else if (run_q) begin
      if (step_q == ST_LAST) begin
        run_d  = 1'b0;
        step_d = '0;
      end else begin
        step_d = step_q + STW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      step_q <= '0;
    end else begin
      run_q  <= run_d;
      step_q <= step_d;
    end
  end

  assign run_o  = run_q;
  assign step_o = step_q;
endmodule

// File: rtl/irq_seq_ctx.sv
module irq_seq_ctx
  import irq_entry_pkg::*;
#(
  parameter logic [AW-1:0] VEC_BASE = 20'hFFD00
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept_i,
  input  logic           run_i,
  input  logic [STW-1:0] step_i,
  input  logic           sw_int_i,
  input  logic [FW-1:0]  flg_i,
  input  logic [AW-1:0]  pc_i,
  input  logic [DW-1:0]  sp_i,
  input  logic [DW-1:0]  rdata_i,
  output logic [FW-1:0]  tmp_flg_o,
  output logic [AW-1:0]  pc_sv_o,
  output logic [DW-1:0]  sp_sv_o,
  output logic [FW-1:0]  flg_clr_o,
  output logic [FW-1:0]  flg_lvl_o,
  output logic [AW-1:0]  vec_addr_o,
  output logic [AW-1:0]  pc_new_o
);
  logic [FW-1:0] tmp_q;
  logic [AW-1:0] pc_q;
  logic [DW-1:0] sp_q;
  logic          sw_q;
  logic [NW-1:0] num_q;
  logic [LW-1:0] lvl_q;
  logic [DW-1:0] vlo_q;
  logic [DW-1:0] vhi_q;

  logic info_en, vlo_en, vhi_en;
  assign info_en = run_i && (step_i == ST_INFO);
  assign vlo_en  = run_i && (step_i == ST_VLO);
  assign vhi_en  = run_i && (step_i == ST_VHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmp_q <= '0;
      pc_q  <= '0;
      sp_q  <= '0;
      sw_q  <= 1'b0;
      num_q <= '0;
      lvl_q <= '0;
      vlo_q <= '0;
      vhi_q <= '0;
    end else begin
      if (accept_i) begin
        tmp_q <= flg_i;
        pc_q  <= pc_i;
        sp_q  <= sp_i;
        sw_q  <= sw_int_i;
      end
      if (info_en) begin
        num_q <= rdata_i[NW-1:0];
        lvl_q <= rdata_i[INF_LVL +: LW];
      end
      if (vlo_en) vlo_q <= rdata_i;
      if (vhi_en) vhi_q <= rdata_i;
    end
  end

  logic keep_u;
  assign keep_u = sw_q && num_q[NW-1];

  always_comb begin
    flg_clr_o        = tmp_q;
    flg_clr_o[FB_I]  = 1'b0;
    flg_clr_o[FB_D]  = 1'b0;
    if (!keep_u) flg_clr_o[FB_U] = 1'b0;
    flg_lvl_o                 = flg_clr_o;
    flg_lvl_o[FB_LVL +: LW]   = lvl_q;
  end

  assign tmp_flg_o  = tmp_q;
  assign pc_sv_o    = pc_q;
  assign sp_sv_o    = sp_q;
  assign vec_addr_o = VEC_BASE + {{(AW-NW-2){1'b0}}, num_q, 2'b00};
  assign pc_new_o   = {vhi_q[AW-DW-1:0], vlo_q};
endmodule

// File: rtl/irq_seq_bus.sv
module irq_seq_bus
  import irq_entry_pkg::*;
#(
  parameter logic [AW-1:0] INFO_ADDR = '0
)(
  input  logic           run_i,
  input  logic [STW-1:0] step_i,
  input  logic           q_ready_i,
  input  logic [DW-1:0]  rdata_i,
  input  logic [FW-1:0]  tmp_flg_i,
  input  logic [AW-1:0]  pc_sv_i,
  input  logic [DW-1:0]  sp_sv_i,
  input  logic [FW-1:0]  flg_clr_i,
  input  logic [FW-1:0]  flg_lvl_i,
  input  logic [AW-1:0]  vec_addr_i,
  output logic [AW-1:0]  addr_o,
  output logic           rd_o,
  output logic           wr_o,
  output logic [DW-1:0]  wdata_o,
  output logic           ack_o,
  output logic [NW-1:0]  ack_num_o,
  output logic           flg_we_o,
  output logic [FW-1:0]  flg_o,
  output logic           sp_we_o
);
  always_comb begin
    addr_o    = '0;
    rd_o      = 1'b0;
    wr_o      = 1'b0;
    wdata_o   = '0;
    ack_o     = 1'b0;
    ack_num_o = '0;
    flg_we_o  = 1'b0;
    flg_o     = '0;
    sp_we_o   = 1'b0;
    if (run_i) begin
      if (step_i == ST_INFO) begin
        addr_o    = INFO_ADDR;
        rd_o      = 1'b1;
        ack_o     = 1'b1;
        ack_num_o = rdata_i[NW-1:0];
      end
      if (step_i >= ST_QFST && step_i <= ST_QLST && q_ready_i) begin
        addr_o = pc_sv_i;
        rd_o   = 1'b1;
      end
      if (step_i == ST_FCLR) begin
        flg_we_o = 1'b1;
        flg_o    = flg_clr_i;
      end
      if (step_i == ST_PUSH1) begin
        addr_o  = {{(AW-DW){1'b0}}, sp_sv_i - DW'(2)};
        wr_o    = 1'b1;
        wdata_o = {pc_sv_i[AW-1:DW], tmp_flg_i};
      end
      if (step_i == ST_PUSH2) begin
        addr_o  = {{(AW-DW){1'b0}}, sp_sv_i - DW'(4)};
        wr_o    = 1'b1;
        wdata_o = pc_sv_i[DW-1:0];
      end
      if (step_i == ST_LVL) begin
        flg_we_o = 1'b1;
        flg_o    = flg_lvl_i;
        sp_we_o  = 1'b1;
      end
      if (step_i == ST_VLO) begin
        addr_o = vec_addr_i;
        rd_o   = 1'b1;
      end
      if (step_i == ST_VHI) begin
        addr_o = vec_addr_i + AW'(2);
        rd_o   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter logic [AW-1:0] VEC_BASE  = 20'hFFD00,
  parameter logic [AW-1:0] INFO_ADDR = 20'h00000
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          insn_done_i,
  input  logic          str_susp_i,
  input  logic          sw_int_i,
  input  logic          q_ready_i,
  input  logic [FW-1:0] flg_i,
  input  logic [AW-1:0] pc_i,
  input  logic [DW-1:0] sp_i,
  output logic [AW-1:0] addr_o,
  output logic          rd_o,
  output logic          wr_o,
  output logic [DW-1:0] wdata_o,
  input  logic [DW-1:0] rdata_i,
  output logic          ack_o,
  output logic [NW-1:0] ack_num_o,
  output logic          busy_o,
  output logic          flg_we_o,
  output logic [FW-1:0] flg_o,
  output logic          sp_we_o,
  output logic [DW-1:0] sp_o,
  output logic          pc_we_o,
  output logic [AW-1:0] pc_o
);
  // reset asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic           accept, run;
  logic [STW-1:0] step;
  logic [FW-1:0]  tmp_flg, flg_clr, flg_lvl;
  logic [AW-1:0]  pc_sv, vec_addr, pc_new;
  logic [DW-1:0]  sp_sv;

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .req_i(req_i), .insn_done_i(insn_done_i),
    .str_susp_i(str_susp_i), .accept_o(accept), .run_o(run), .step_o(step)
  );

  irq_seq_ctx #(.VEC_BASE(VEC_BASE)) u_ctx (
    .clk(clk), .rst_n(rst_int_n), .accept_i(accept), .run_i(run), .step_i(step),
    .sw_int_i(sw_int_i), .flg_i(flg_i), .pc_i(pc_i), .sp_i(sp_i), .rdata_i(rdata_i),
    .tmp_flg_o(tmp_flg), .pc_sv_o(pc_sv), .sp_sv_o(sp_sv), .flg_clr_o(flg_clr),
    .flg_lvl_o(flg_lvl), .vec_addr_o(vec_addr), .pc_new_o(pc_new)
  );

  irq_seq_bus #(.INFO_ADDR(INFO_ADDR)) u_bus (
    .run_i(run), .step_i(step), .q_ready_i(q_ready_i), .rdata_i(rdata_i),
    .tmp_flg_i(tmp_flg), .pc_sv_i(pc_sv), .sp_sv_i(sp_sv), .flg_clr_i(flg_clr),
    .flg_lvl_i(flg_lvl), .vec_addr_i(vec_addr), .addr_o(addr_o), .rd_o(rd_o),
    .wr_o(wr_o), .wdata_o(wdata_o), .ack_o(ack_o), .ack_num_o(ack_num_o),
    .flg_we_o(flg_we_o), .flg_o(flg_o), .sp_we_o(sp_we_o)
  );

  assign busy_o  = run;
  assign sp_o    = sp_sv - DW'(4);
  assign pc_we_o = run && (step == ST_LAST);
  assign pc_o    = pc_new;
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk
  import irq_entry_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          req_i,
  input logic          insn_done_i,
  input logic          str_susp_i,
  input logic [AW-1:0] addr_o,
  input logic          rd_o,
  input logic          wr_o,
  input logic          ack_o,
  input logic          busy_o,
  input logic          flg_we_o,
  input logic [FW-1:0] flg_o,
  input logic          pc_we_o
);
  logic [7:0] busy_cnt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 8'd1;
    else             busy_cnt_q <= '0;
  end

  a_r1_start_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(req_i && (insn_done_i || str_susp_i)));

  a_r2_ack_on_info_read: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (rd_o && addr_o == '0 && busy_o));

  a_r4_flags_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    flg_we_o |-> (!flg_o[FB_I] && !flg_o[FB_D]));

  a_r8_pc_after_vector: assert property (@(posedge clk) disable iff (!rst_n)
    pc_we_o |-> ($past(rd_o, 2) && busy_o));

  a_r9_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> ($past(busy_cnt_q) == 8'(STEPS - 1)));

  a_r9_bus_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_o && wr_o));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !(rd_o || wr_o || ack_o || flg_we_o || pc_we_o));
endmodule

bind irq_entry_seq irq_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .insn_done_i(insn_done_i),
  .str_susp_i(str_susp_i), .addr_o(addr_o), .rd_o(rd_o), .wr_o(wr_o),
  .ack_o(ack_o), .busy_o(busy_o), .flg_we_o(flg_we_o), .flg_o(flg_o),
  .pc_we_o(pc_we_o)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [19:0] VB = 20'hFFD00;

  localparam int K_ACK = 0, K_RD = 1, K_WR = 2, K_FLG = 3, K_SP = 4, K_PC = 5;

  typedef struct {
    int          step;
    int          kind;
    logic [19:0] addr;
    logic [15:0] data;
    string       rq;
  } ev_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req, done, strs, swi, qr;
  logic [11:0] flg;
  logic [19:0] pc;
  logic [15:0] sp;
  logic [19:0] addr;
  logic rd, wr;
  logic [15:0] wdata, rdata;
  logic ack, busy, flg_we, sp_we, pc_we;
  logic [5:0] ack_num;
  logic [11:0] flg_o;
  logic [15:0] sp_o;
  logic [19:0] pc_o;
  logic [15:0] info_w;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  int last_len = 0;
  bit idle_bad = 0;
  ev_t expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq #(.VEC_BASE(VB)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .insn_done_i(done), .str_susp_i(strs),
    .sw_int_i(swi), .q_ready_i(qr), .flg_i(flg), .pc_i(pc), .sp_i(sp),
    .addr_o(addr), .rd_o(rd), .wr_o(wr), .wdata_o(wdata), .rdata_i(rdata),
    .ack_o(ack), .ack_num_o(ack_num), .busy_o(busy), .flg_we_o(flg_we),
    .flg_o(flg_o), .sp_we_o(sp_we), .sp_o(sp_o), .pc_we_o(pc_we), .pc_o(pc_o)
  );

  function automatic logic [15:0] vword(input logic [19:0] a);
    return a[15:0] ^ 16'h3C5A;
  endfunction

  always_comb rdata = (addr == 20'h0) ? info_w : vword(addr);

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic push(input int st, input int k, input logic [19:0] a,
                      input logic [15:0] d, input string rq);
    ev_t e;
    e.step = st; e.kind = k; e.addr = a; e.data = d; e.rq = rq;
    expq.push_back(e);
  endtask

  task automatic observe(input int k, input logic [19:0] a, input logic [15:0] d);
    ev_t e;
    if (expq.size() == 0) begin
      check(0, "R9", "unexpected event kind/step", 32'(k), 32'(cyc));
    end else begin
      e = expq.pop_front();
      check(e.step == cyc && e.kind == k && e.addr == a && e.data == d, e.rq,
            $sformatf("event step %0d kind %0d addr/data", e.step, e.kind),
            {cyc[7:0], k[3:0], a}, {e.step[7:0], e.kind[3:0], e.addr});
      if (e.data != d) check(0, e.rq, "event data", 32'(d), 32'(e.data));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        if (ack)    observe(K_ACK, {14'b0, ack_num}, 16'h0);
        if (rd)     observe(K_RD, addr, 16'h0);
        if (wr)     observe(K_WR, addr, wdata);
        if (flg_we) observe(K_FLG, 20'h0, {4'h0, flg_o});
        if (sp_we)  observe(K_SP, 20'h0, sp_o);
        if (pc_we)  observe(K_PC, pc_o, 16'h0);
        cyc++;
      end else begin
        if (cyc != 0) last_len = cyc;
        cyc = 0;
        if (rd || wr || ack || flg_we || sp_we || pc_we) idle_bad = 1;
      end
    end
  end

  // expected events for one entry sequence
  task automatic push_exp(input int num, input int lvl, input bit sw, input bit q,
                          input logic [11:0] f, input logic [19:0] p, input logic [15:0] s);
    logic [11:0] fc, fl;
    logic [19:0] va;
    logic [15:0] s2, s4;
    bit keep_u;
    keep_u = sw && (num >= 32);
    fc = f;
    fc[6] = 1'b0;
    fc[1] = 1'b0;
    if (!keep_u) fc[7] = 1'b0;
    fl = fc;
    fl[10:8] = 3'(lvl);
    va = VB + 20'(num * 4);
    s2 = s - 16'd2;
    s4 = s - 16'd4;
    push(0, K_ACK, 20'(num), 16'h0, "R2");
    push(0, K_RD, 20'h0, 16'h0, "R2");
    if (q) for (int i = 1; i <= 3; i++) push(i, K_RD, p, 16'h0, "R3");
    push(4, K_FLG, 20'h0, {4'h0, fc}, sw ? "R5" : "R4");
    push(8, K_WR, {4'h0, s2}, {p[19:16], f}, "R6");
    push(10, K_WR, {4'h0, s4}, p[15:0], "R6");
    push(12, K_FLG, 20'h0, {4'h0, fl}, "R7");
    push(12, K_SP, 20'h0, s4, "R7");
    push(13, K_RD, va, 16'h0, "R8");
    push(15, K_RD, va + 20'd2, 16'h0, "R8");
    push(17, K_PC, {vword(va + 20'd2)[3:0], vword(va)}, 16'h0, "R8");
  endtask

  // drive one request and wait for the sequence to end
  task automatic run_irq(input int num, input int lvl, input bit sw, input bit str_mode,
                         input bit q, input logic [11:0] f, input logic [19:0] p,
                         input logic [15:0] s);
    push_exp(num, lvl, sw, q, f, p, s);
    @(posedge clk); #1;
    info_w = {5'b0, 3'(lvl), 2'b0, 6'(num)};
    flg = f; pc = p; sp = s; swi = sw; qr = q;
    req = 1'b1; done = !str_mode; strs = str_mode;
    @(posedge clk); #1;
    check(busy === 1'b1, "R1", "busy after accept", 32'(busy), 32'd1);
    req = 1'b0; done = 1'b0; strs = 1'b0; swi = 1'b0;
    flg = '0; pc = '0; sp = '0;
    repeat (18) @(posedge clk);
    #1;
    check(busy === 1'b0, "R9", "busy low after 18 cycles", 32'(busy), 32'd0);
    @(posedge clk); #1;
    check(last_len == 18, "R9", "busy length", 32'(last_len), 32'd18);
    check(expq.size() == 0, "R9", "events left over", 32'(expq.size()), 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    check(0, "R9", "watchdog expired", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req = 0; done = 0; strs = 0; swi = 0; qr = 0;
    flg = '0; pc = '0; sp = '0; info_w = '0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && rd === 1'b0 && wr === 1'b0, "R9", "reset state",
          {busy, rd, wr}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: pending request without a boundary is not accepted
    #1;
    req = 1'b1;
    info_w = {5'b0, 3'd2, 2'b0, 6'd9};
    begin
      bit seen;
      seen = 0;
      for (int i = 0; i < 6; i++) begin
        @(posedge clk); #1;
        if (busy) seen = 1;
      end
      check(!seen, "R1", "no start without boundary", 32'(seen), 32'd0);
    end
    req = 1'b0;

    // hardware interrupt at a boundary, queue ready: R2 R3 R4 R6 R7 R8
    run_irq(5, 3, 1'b0, 1'b0, 1'b1, 12'hFFF, 20'hA1234, 16'h2000);
    // string suspend entry, queue not ready: R1 R3
    run_irq(17, 6, 1'b0, 1'b1, 1'b0, 12'h0C3, 20'h5ABCD, 16'h0400);
    // software interrupt 40 keeps U: R5
    run_irq(40, 0, 1'b1, 1'b0, 1'b1, 12'h7C2, 20'h00010, 16'h1002);
    // software interrupt 20 clears U: R5
    run_irq(20, 7, 1'b1, 1'b0, 1'b0, 12'h0FF, 20'hFFFFE, 16'h0003);
    // number 63 boundary, SP wraps: R6 R8
    run_irq(63, 1, 1'b0, 1'b1, 1'b1, 12'h8A0, 20'h3C3C3, 16'h0002);

    // R9: held request is taken only after busy falls
    push_exp(12, 4, 1'b0, 1'b1, 12'h044, 20'h11111, 16'h3000);
    push_exp(12, 4, 1'b0, 1'b1, 12'h044, 20'h11111, 16'h3000);
    @(posedge clk); #1;
    info_w = {5'b0, 3'd4, 2'b0, 6'd12};
    flg = 12'h044; pc = 20'h11111; sp = 16'h3000; qr = 1'b1;
    req = 1'b1; done = 1'b1;
    @(posedge clk); #1;
    check(busy === 1'b1, "R1", "busy after held accept", 32'(busy), 32'd1);
    repeat (18) @(posedge clk);
    #1;
    check(busy === 1'b0, "R9", "gap after first run", 32'(busy), 32'd0);
    @(posedge clk); #1;
    check(busy === 1'b1, "R9", "held request taken", 32'(busy), 32'd1);
    check(last_len == 18, "R9", "first held run length", 32'(last_len), 32'd18);
    req = 1'b0; done = 1'b0;
    repeat (19) @(posedge clk);
    #1;
    check(last_len == 18, "R9", "second held run length", 32'(last_len), 32'd18);
    check(expq.size() == 0, "R9", "held events left", 32'(expq.size()), 32'd0);

    check(!idle_bad, "R9", "strobes while idle", 32'(idle_bad), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule